// File: doc/BRIEF.md
# Tag-Reuse Mode Controller

This block sits beside a set-associative instruction cache and its branch buffer and decides, for every fetch, how the cache is accessed. In the normal mode every way is enabled and tags are compared. When a fetch hits in the branch buffer and no hit-way history is stored for the predicted outcome, the controller enters a tracing mode. In that mode it keeps checking tags, remembers the branch address and prediction, and appends the hit way of each following fetch to a recording register. The next branch-buffer hit ends the trace and writes the recorded ways back to the entry of the remembered branch.

When a later visit to that branch finds stored ways, the controller enters an omitting mode. It loads the ways into a replay register and, for each following fetch, enables only the recorded way with tag comparison switched off. When the last recorded way has been used, it returns to normal accesses. Four kinds of event drop the controller back to normal mode from any mode: a cache miss, a branch-buffer replacement, a return-stack access or a branch misprediction. A cache miss also asks the branch buffer to invalidate every stored way list, because the cache contents have changed.

Top module: `tagreuse_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (normal), tag_chk_o is 1, way_en_o has all bits set, and wp_wr_o and wp_inv_all_o are 0.
- R2: In normal mode, a fetch with btb_hit_i and btb_wp_cnt_i > 0 moves mode_o to 2 (omitting) on the next cycle. A fetch with btb_hit_i and btb_wp_cnt_i = 0 moves it to 1 (tracing). A fetch without a hit leaves the mode at 0.
- R3: Entering tracing saves pc_i and pred_taken_i. The fetch that ends the trace with a branch-buffer hit raises wp_wr_o for that cycle and presents the saved values on wp_wr_pc_o and wp_wr_taken_o. The mode is then normal.
- R4: In tracing mode, each fetch without a hit stores ic_hit_way_i in the next free slot. Slot i of wp_wr_data_o and btb_wp_i occupies bits [i*WAY_W +: WAY_W], in fetch order.
- R5: wp_wr_cnt_o gives the number of slots filled. Once NUM_WP ways have been stored, further ways are dropped and the count stays at NUM_WP.
- R6: In omitting mode, tag_chk_o is 0 and way_en_o is one-hot on the next pointer in slot order. Each fetch uses up one pointer. After the last pointer has been used, the mode returns to normal.
- R7: If ic_miss_i, btb_repl_i, ras_access_i or mispred_i is asserted, the mode is normal on the next cycle, whatever the current mode and fetch inputs.
- R8: wp_inv_all_o is asserted in exactly the cycles in which ic_miss_i is asserted. The other forcing events do not assert it.
- R9: Priorities: a forcing event in the cycle that would end a trace suppresses wp_wr_o. A trace-ending hit with btb_wp_cnt_i > 0 writes and goes to normal mode, not to omitting.
- R10: In omitting mode, btb_hit_i has no effect. The pointer still advances, and the mode stays omitting until the pointers are used up.
- R11: A cycle with fetch_vld_i low and no forcing event changes neither the mode nor the replay position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | A fetch takes place this cycle |
| pc_i | input | PC_W | Address of the current fetch |
| btb_hit_i | input | 1 | Current fetch hits in the branch buffer |
| pred_taken_i | input | 1 | Predicted outcome of the hitting branch |
| btb_wp_i | input | NUM_WP*WAY_W | Stored way pointers for the predicted outcome |
| btb_wp_cnt_i | input | CNT_W | Number of valid stored pointers (0 = none) |
| ic_hit_way_i | input | WAY_W | Hit way reported by the cache tag check |
| ic_miss_i | input | 1 | Cache miss |
| mispred_i | input | 1 | Branch misprediction |
| ras_access_i | input | 1 | Return-stack access |
| btb_repl_i | input | 1 | Branch-buffer entry replaced |
| mode_o | output | 2 | 0 normal, 1 tracing, 2 omitting |
| tag_chk_o | output | 1 | Tag comparison enabled for this fetch |
| way_en_o | output | WAYS | Data-way enables for this fetch |
| wp_wr_o | output | 1 | Write a recorded way list to the branch buffer |
| wp_wr_pc_o | output | PC_W | Branch address for the write |
| wp_wr_taken_o | output | 1 | Outcome field selected by the write |
| wp_wr_data_o | output | NUM_WP*WAY_W | Recorded way pointers |
| wp_wr_cnt_o | output | CNT_W | Number of valid recorded pointers |
| wp_inv_all_o | output | 1 | Invalidate all stored way lists |

## Verification
The hardest state to reach is a trace that overflows the recording register and is then closed by a hit that itself carries stored pointers. In that state the prefix limit and the priority of the write over entering the omitting mode both apply in the same cycle. Random fetch streams rarely produce a long enough run between branch hits, so directed sequences build it explicitly. They also feed a recorded list back as the buffer response, to follow a replay through an idle cycle and a stray hit. Random traffic with rare forcing events then mixes these paths, and a cycle-level reference model in the bench checks every output.

// File: rtl/tagreuse_pkg.sv
package tagreuse_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_TRACE = 2'd1,
    MODE_OMIT  = 2'd2
  } mode_e;
endpackage

// File: rtl/tr_mode_fsm.sv
module tr_mode_fsm
  import tagreuse_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fetch_i,
  input  logic  hit_i,
  input  logic  ptrs_avail_i,
  input  logic  force_i,
  input  logic  replay_last_i,
  output mode_e mode_o,
  output logic  trace_start_o,
  output logic  omit_start_o,
  output logic  rec_push_o,
  output logic  rec_write_o,
  output logic  replay_adv_o
);

  mode_e mode_q, mode_d;

  always_comb begin
    mode_d        = mode_q;
    trace_start_o = 1'b0;
    omit_start_o  = 1'b0;
    rec_push_o    = 1'b0;
    rec_write_o   = 1'b0;
    replay_adv_o  = 1'b0;
    if (force_i) begin
      // disturbing event wins over everything
      mode_d = MODE_NORM;
    end else if (fetch_i) begin
      unique case (mode_q)
        MODE_NORM: begin
          if (hit_i) begin
            if (ptrs_avail_i) begin
              omit_start_o = 1'b1;
              mode_d       = MODE_OMIT;
            end else begin
              trace_start_o = 1'b1;
              mode_d        = MODE_TRACE;
            end
          end
        end
        MODE_TRACE: begin
          if (hit_i) begin
            // write beats re-entry: next branch decision waits one visit
            rec_write_o = 1'b1;
            mode_d      = MODE_NORM;
          end else begin
            rec_push_o = 1'b1;
          end
        end
        MODE_OMIT: begin
          replay_adv_o = 1'b1;
          if (replay_last_i) mode_d = MODE_NORM;
        end
        default: mode_d = MODE_NORM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORM;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/tr_rec_buf.sv
module tr_rec_buf #(
  parameter int PC_W   = 32,
  parameter int WAY_W  = 2,
  parameter int NUM_WP = 4,
  parameter int CNT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic                    taken_i,
  input  logic                    push_i,
  input  logic [WAY_W-1:0]        way_i,
  output logic [PC_W-1:0]         pend_pc_o,
  output logic                    pend_taken_o,
  output logic [NUM_WP*WAY_W-1:0] rec_o,
  output logic [CNT_W-1:0]        cnt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_WP);

  logic [PC_W-1:0]  pend_pc_q;
  logic             pend_taken_q;
  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room = (cnt_q < FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_pc_q    <= '0;
      pend_taken_q <= 1'b0;
      cnt_q        <= '0;
    end else if (start_i) begin
      pend_pc_q    <= pc_i;
      pend_taken_q <= taken_i;
      cnt_q        <= '0;
    end else if (push_i && room) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // one slot register per pointer; a full buffer matches no slot, so excess ways drop
  for (genvar s = 0; s < NUM_WP; s++) begin : g_slot
    logic [WAY_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q <= '0;
      else if (push_i && !start_i && cnt_q == CNT_W'(s)) slot_q <= way_i;
    end
    assign rec_o[s*WAY_W +: WAY_W] = slot_q;
  end

  assign pend_pc_o    = pend_pc_q;
  assign pend_taken_o = pend_taken_q;
  assign cnt_o        = cnt_q;

endmodule

// File: rtl/tr_replay_buf.sv
module tr_replay_buf #(
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int NUM_WP = 4,
  parameter int CNT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [NUM_WP*WAY_W-1:0] ptrs_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    adv_i,
  output logic [WAYS-1:0]         way_en_o,
  output logic                    last_o
);

  logic [NUM_WP*WAY_W-1:0] ptr_q;
  logic [CNT_W-1:0]        cnt_q, idx_q;
  logic [WAY_W-1:0]        cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      ptr_q <= ptrs_i;
      cnt_q <= cnt_i;
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (idx_q == CNT_W'(i)) cur = ptr_q[i*WAY_W +: WAY_W];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_dec
    assign way_en_o[w] = (cur == WAY_W'(w));
  end

  assign last_o = ((idx_q + CNT_W'(1)) == cnt_q);

endmodule

// File: rtl/tagreuse_ctrl.sv
module tagreuse_ctrl
  import tagreuse_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int WAYS   = 4,
  parameter int NUM_WP = 4,
  // derived
  parameter int WAY_W  = $clog2(WAYS),
  parameter int CNT_W  = $clog2(NUM_WP + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_vld_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic                    btb_hit_i,
  input  logic                    pred_taken_i,
  input  logic [NUM_WP*WAY_W-1:0] btb_wp_i,
  input  logic [CNT_W-1:0]        btb_wp_cnt_i,
  input  logic [WAY_W-1:0]        ic_hit_way_i,
  input  logic                    ic_miss_i,
  input  logic                    mispred_i,
  input  logic                    ras_access_i,
  input  logic                    btb_repl_i,
  output logic [1:0]              mode_o,
  output logic                    tag_chk_o,
  output logic [WAYS-1:0]         way_en_o,
  output logic                    wp_wr_o,
  output logic [PC_W-1:0]         wp_wr_pc_o,
  output logic                    wp_wr_taken_o,
  output logic [NUM_WP*WAY_W-1:0] wp_wr_data_o,
  output logic [CNT_W-1:0]        wp_wr_cnt_o,
  output logic                    wp_inv_all_o
);

  mode_e           mode;
  logic            force_norm;
  logic            trace_start, omit_start, rec_push, rec_write, replay_adv, replay_last;
  logic [WAYS-1:0] replay_en;

  assign force_norm = ic_miss_i | btb_repl_i | ras_access_i | mispred_i;

  tr_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_i       (fetch_vld_i),
    .hit_i         (btb_hit_i),
    .ptrs_avail_i  (btb_wp_cnt_i != '0),
    .force_i       (force_norm),
    .replay_last_i (replay_last),
    .mode_o        (mode),
    .trace_start_o (trace_start),
    .omit_start_o  (omit_start),
    .rec_push_o    (rec_push),
    .rec_write_o   (rec_write),
    .replay_adv_o  (replay_adv)
  );

  tr_rec_buf #(
    .PC_W(PC_W), .WAY_W(WAY_W), .NUM_WP(NUM_WP), .CNT_W(CNT_W)
  ) u_rec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (trace_start),
    .pc_i         (pc_i),
    .taken_i      (pred_taken_i),
    .push_i       (rec_push),
    .way_i        (ic_hit_way_i),
    .pend_pc_o    (wp_wr_pc_o),
    .pend_taken_o (wp_wr_taken_o),
    .rec_o        (wp_wr_data_o),
    .cnt_o        (wp_wr_cnt_o)
  );

  tr_replay_buf #(
    .WAYS(WAYS), .WAY_W(WAY_W), .NUM_WP(NUM_WP), .CNT_W(CNT_W)
  ) u_replay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (omit_start),
    .ptrs_i   (btb_wp_i),
    .cnt_i    (btb_wp_cnt_i),
    .adv_i    (replay_adv),
    .way_en_o (replay_en),
    .last_o   (replay_last)
  );

  assign mode_o       = mode;
  assign tag_chk_o    = (mode != MODE_OMIT);
  assign way_en_o     = (mode == MODE_OMIT) ? replay_en : {WAYS{1'b1}};
  assign wp_wr_o      = rec_write;
  assign wp_inv_all_o = ic_miss_i;

endmodule

// File: rtl/tagreuse_ctrl_chk.sv
module tagreuse_ctrl_chk #(
  parameter int WAYS   = 4,
  parameter int NUM_WP = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_vld_i,
  input logic             btb_hit_i,
  input logic [CNT_W-1:0] btb_wp_cnt_i,
  input logic             ic_miss_i,
  input logic             mispred_i,
  input logic             ras_access_i,
  input logic             btb_repl_i,
  input logic [1:0]       mode_o,
  input logic             tag_chk_o,
  input logic [WAYS-1:0]  way_en_o,
  input logic             wp_wr_o,
  input logic [CNT_W-1:0] wp_wr_cnt_o,
  input logic             wp_inv_all_o
);

  logic any_force;
  assign any_force = ic_miss_i | mispred_i | ras_access_i | btb_repl_i;

  // R1
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  // R2
  enter_omit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && fetch_vld_i && btb_hit_i && btb_wp_cnt_i != '0 && !any_force)
    |=> mode_o == 2'd2);

  // R5
  wr_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_wr_o |-> wp_wr_cnt_o <= CNT_W'(NUM_WP));

  // R6
  conv_all_ways_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_chk_o |-> &way_en_o);

  // R6
  omit_single_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_chk_o |-> $countones(way_en_o) == 1);

  // R7
  force_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_force |=> mode_o == 2'd0);

  // R8
  miss_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ic_miss_i |-> wp_inv_all_o && !wp_wr_o);

  // R9
  wr_no_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_wr_o |-> !any_force && mode_o == 2'd1);

  // R9
  wr_then_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_wr_o |=> mode_o == 2'd0);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_vld_i && !any_force) |=> $stable(mode_o) && $stable(way_en_o));

endmodule

bind tagreuse_ctrl tagreuse_ctrl_chk #(
  .WAYS(WAYS), .NUM_WP(NUM_WP), .CNT_W(CNT_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_vld_i  (fetch_vld_i),
  .btb_hit_i    (btb_hit_i),
  .btb_wp_cnt_i (btb_wp_cnt_i),
  .ic_miss_i    (ic_miss_i),
  .mispred_i    (mispred_i),
  .ras_access_i (ras_access_i),
  .btb_repl_i   (btb_repl_i),
  .mode_o       (mode_o),
  .tag_chk_o    (tag_chk_o),
  .way_en_o     (way_en_o),
  .wp_wr_o      (wp_wr_o),
  .wp_wr_cnt_o  (wp_wr_cnt_o),
  .wp_inv_all_o (wp_inv_all_o)
);

// File: tb/tagreuse_ctrl_tb_top.sv
module tagreuse_ctrl_tb_top;
  localparam int PC_W   = 32;
  localparam int WAYS   = 4;
  localparam int NUM_WP = 4;
  localparam int WAY_W  = 2;
  localparam int CNT_W  = 3;
  localparam int DW     = NUM_WP * WAY_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fetch_vld = 1'b0, btb_hit = 1'b0, pred_taken = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic [DW-1:0]   btb_wp = '0;
  logic [CNT_W-1:0] btb_wp_cnt = '0;
  logic [WAY_W-1:0] hit_way = '0;
  logic            ic_miss = 1'b0, mispred = 1'b0, ras_acc = 1'b0, btb_repl = 1'b0;
  logic [1:0]      mode;
  logic            tag_chk, wp_wr, wp_wr_taken, wp_inv_all;
  logic [WAYS-1:0] way_en;
  logic [PC_W-1:0] wp_wr_pc;
  logic [DW-1:0]   wp_wr_data;
  logic [CNT_W-1:0] wp_wr_cnt;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tagreuse_ctrl #(.PC_W(PC_W), .WAYS(WAYS), .NUM_WP(NUM_WP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_vld_i(fetch_vld), .pc_i(pc),
    .btb_hit_i(btb_hit), .pred_taken_i(pred_taken), .btb_wp_i(btb_wp),
    .btb_wp_cnt_i(btb_wp_cnt), .ic_hit_way_i(hit_way), .ic_miss_i(ic_miss),
    .mispred_i(mispred), .ras_access_i(ras_acc), .btb_repl_i(btb_repl),
    .mode_o(mode), .tag_chk_o(tag_chk), .way_en_o(way_en), .wp_wr_o(wp_wr),
    .wp_wr_pc_o(wp_wr_pc), .wp_wr_taken_o(wp_wr_taken), .wp_wr_data_o(wp_wr_data),
    .wp_wr_cnt_o(wp_wr_cnt), .wp_inv_all_o(wp_inv_all)
  );

  // reference model state
  int              m_mode = 0;
  logic [PC_W-1:0] m_pc = '0;
  bit              m_tk = 0;
  logic [DW-1:0]   m_rec = '0;
  int              m_rcnt = 0;
  logic [DW-1:0]   m_rp = '0;
  int              m_rpcnt = 0, m_rpidx = 0;

  logic [DW-1:0]   last_wr_data = '0;
  logic [PC_W-1:0] last_wr_pc = '0;
  bit              last_wr_tk = 0;
  int              last_wr_cnt = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WAYS-1:0] exp_way_en();
    logic [WAYS-1:0] e;
    if (m_mode != 2) return '1;
    e = '0;
    e[m_rp[m_rpidx*WAY_W +: WAY_W]] = 1'b1;
    return e;
  endfunction

  function automatic logic [63:0] prefix_mask(int n);
    return (64'd1 << (n * WAY_W)) - 64'd1;
  endfunction

  task automatic step(bit fv, bit hit, bit tk, logic [PC_W-1:0] a, int wcnt,
                      logic [DW-1:0] wdat, logic [WAY_W-1:0] hw,
                      bit miss, bit mp, bit ras, bit rep);
    bit force_n, exp_wr;
    int n_mode, n_rcnt, n_rpidx, n_rpcnt;
    logic [DW-1:0] n_rec, n_rp;
    logic [PC_W-1:0] n_pc;
    bit n_tk;
    fetch_vld = fv; btb_hit = hit; pred_taken = tk; pc = a;
    btb_wp_cnt = CNT_W'(wcnt); btb_wp = wdat; hit_way = hw;
    ic_miss = miss; mispred = mp; ras_acc = ras; btb_repl = rep;
    #1;
    force_n = miss | mp | ras | rep;
    exp_wr  = fv && hit && (m_mode == 1) && !force_n;
    check("R2 mode", 64'(mode), 64'(m_mode));
    check("R6 tag_chk", 64'(tag_chk), 64'(m_mode != 2));
    check("R6 way_en", 64'(way_en), 64'(exp_way_en()));
    check("R8 inv_all", 64'(wp_inv_all), 64'(miss));
    check("R9 wp_wr", 64'(wp_wr), 64'(exp_wr));
    if (wp_wr) begin
      last_wr_data = wp_wr_data; last_wr_pc = wp_wr_pc;
      last_wr_tk = wp_wr_taken; last_wr_cnt = int'(wp_wr_cnt);
    end
    if (exp_wr) begin
      check("R3 wr_pc", 64'(wp_wr_pc), 64'(m_pc));
      check("R3 wr_taken", 64'(wp_wr_taken), 64'(m_tk));
      check("R5 wr_cnt", 64'(wp_wr_cnt), 64'(m_rcnt));
      check("R4 wr_data", 64'(wp_wr_data) & prefix_mask(m_rcnt),
            64'(m_rec) & prefix_mask(m_rcnt));
    end
    n_mode = m_mode; n_rcnt = m_rcnt; n_rec = m_rec; n_pc = m_pc; n_tk = m_tk;
    n_rp = m_rp; n_rpcnt = m_rpcnt; n_rpidx = m_rpidx;
    if (force_n) n_mode = 0;
    else if (fv) begin
      case (m_mode)
        0: if (hit) begin
             if (wcnt > 0) begin n_mode = 2; n_rp = wdat; n_rpcnt = wcnt; n_rpidx = 0; end
             else begin n_mode = 1; n_pc = a; n_tk = tk; n_rcnt = 0; end
           end
        1: if (hit) n_mode = 0;
           else if (m_rcnt < NUM_WP) begin
             n_rec[m_rcnt*WAY_W +: WAY_W] = hw; n_rcnt = m_rcnt + 1;
           end
        default: begin
          if (m_rpidx + 1 == m_rpcnt) n_mode = 0;
          n_rpidx = m_rpidx + 1;
        end
      endcase
    end
    @(posedge clk);
    m_mode = n_mode; m_rcnt = n_rcnt; m_rec = n_rec; m_pc = n_pc; m_tk = n_tk;
    m_rp = n_rp; m_rpcnt = n_rpcnt; m_rpidx = n_rpidx;
    @(negedge clk);
  endtask

  task automatic fetch(logic [WAY_W-1:0] w);
    step(1, 0, 0, 32'h1000, 0, '0, w, 0, 0, 0, 0);
  endtask
  task automatic branch(logic [PC_W-1:0] a, bit tk, int c, logic [DW-1:0] d);
    step(1, 1, tk, a, c, d, 2'd0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", 64'(mode), 64'd0);
    check("R1 tag_chk", 64'(tag_chk), 64'd1);
    check("R1 way_en", 64'(way_en), 64'hF);
    check("R1 wr/inv", 64'({wp_wr, wp_inv_all}), 64'd0);

    // R3/R4: trace three ways after branch at 0x100 taken
    fetch(2'd1);
    branch(32'h100, 1, 0, '0);
    check("R2 enter trace", 64'(mode), 64'd1);
    fetch(2'd2); fetch(2'd0); fetch(2'd3);
    branch(32'h200, 0, 0, '0);
    check("R3 wr_pc", 64'(last_wr_pc), 64'h100);
    check("R3 wr_taken", 64'(last_wr_tk), 64'd1);
    check("R4 wr_data", 64'(last_wr_data[5:0]), 64'b11_00_10);
    check("R3 back to normal", 64'(mode), 64'd0);

    // R6/R10/R11: replay the recorded list
    branch(32'h100, 1, 3, 8'b00_11_00_10);
    check("R2 enter omit", 64'(mode), 64'd2);
    check("R6 first way", 64'(way_en), 64'b0100);
    step(0, 0, 0, 32'h0, 0, '0, 2'd0, 0, 0, 0, 0);
    check("R11 idle holds mode", 64'(mode), 64'd2);
    check("R11 idle holds way", 64'(way_en), 64'b0100);
    fetch(2'd0);
    step(1, 1, 0, 32'h180, 2, 8'hFF, 2'd0, 0, 0, 0, 0);
    check("R10 hit ignored in omit", 64'(mode), 64'd2);
    check("R10 pointer advanced", 64'(way_en), 64'b1000);
    fetch(2'd0);
    check("R6 list exhausted", 64'(mode), 64'd0);

    // R5/R9: overflow, closed by a hit that carries pointers
    branch(32'h300, 0, 0, '0);
    fetch(2'd1); fetch(2'd2); fetch(2'd3); fetch(2'd0); fetch(2'd2); fetch(2'd1);
    branch(32'h400, 1, 2, 8'h0E);
    check("R5 wr_cnt saturates", 64'(last_wr_cnt), 64'(NUM_WP));
    check("R5 prefix kept", 64'(last_wr_data), 64'b00_11_10_01);
    check("R9 write beats omit entry", 64'(mode), 64'd0);

    // R7: misprediction in omitting mode
    branch(32'h500, 1, 3, 8'h1B);
    step(1, 0, 0, 32'h504, 0, '0, 2'd0, 0, 1, 0, 0);
    check("R7 mispred forces normal", 64'(mode), 64'd0);
    // R9: return-stack access cancels the record write
    branch(32'h600, 0, 0, '0);
    fetch(2'd3);
    step(1, 1, 0, 32'h700, 0, '0, 2'd0, 0, 0, 1, 0);
    check("R9 force suppresses write", 64'(last_wr_pc), 64'h300);
    check("R7 ras forces normal", 64'(mode), 64'd0);
    // R8: miss while tracing
    branch(32'h800, 1, 0, '0);
    step(1, 0, 0, 32'h804, 0, '0, 2'd1, 1, 0, 0, 0);
    check("R8 miss ends trace", 64'(mode), 64'd0);
    // R7: replacement with no fetch
    branch(32'h900, 1, 1, 8'h02);
    step(0, 0, 0, 32'h0, 0, '0, 2'd0, 0, 0, 0, 1);
    check("R7 replacement forces normal", 64'(mode), 64'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit fv, hit, miss, mp, ras, rep;
      int c;
      fv   = ($urandom_range(0, 99) < 85);
      hit  = ($urandom_range(0, 99) < 15);
      miss = ($urandom_range(0, 99) < 2);
      mp   = ($urandom_range(0, 99) < 2);
      ras  = ($urandom_range(0, 99) < 1);
      rep  = ($urandom_range(0, 99) < 1);
      c    = $urandom_range(0, NUM_WP);
      step(fv, hit, 1'($urandom_range(0, 1)), $urandom, c, DW'($urandom),
           WAY_W'($urandom_range(0, WAYS - 1)), miss, mp, ras, rep);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule